// File: doc/BRIEF.md
# PWM Generator and Pulse Capture Timer

This block is one timer with a single shared counter that runs in one of two modes. In generation mode it drives its pin with a pulse train. Software programs the period length and the high time in clock cycles. New settings are taken over only at the end of the period that is running. In capture mode the pin becomes an input and the block measures the incoming waveform. One control bit selects whether the high or the low part of the wave is timed, and the full period is measured in both cases. Each completed period stores both numbers and raises an interrupt flag.

Software reaches the block through a flat register port. A write strobe, an address and write data take effect at the clock edge. Read data appears one cycle after the address is presented. The pin input passes through a synchronizer chain before its edges are used. If a period exceeds the counter range, the counter saturates and a sticky overflow flag is set.

Top module: `pwm_capture_timer`

## Requirements
- R1: After reset, pin_out, pin_oe and irq are 0, and every register at addresses 0 to 5 reads 0.
- R2: Control is at address 0: bit 0 enables, bit 1 selects capture (1) or generation (0), bit 2 selects low-width capture. The period is at address 1 and the width at address 2. When enabled in generation mode, the output repeats every P cycles, where P is the period value and a value of 0 acts as 1. It is high for min(W, P) cycles of each period, where W is the width value, so W=0 holds it low and W>=P holds it high.
- R3: A width or period written while generation runs takes effect only at the next period boundary. Every complete high pulse therefore has either the old or the new width, and once a pulse with the new width appears, no pulse with the old width follows.
- R4: pin_oe is 1 only while the block is enabled in generation mode. It is 0 in capture mode.
- R5: In high-width capture, the captured period (address 3) is the number of clocks between successive rising edges. The captured width (address 4) is the number of clocks from a rising edge to the next falling edge.
- R6: In low-width capture, the period runs between successive falling edges and the width runs from a falling edge to the next rising edge.
- R7: Status is at address 5: bit 0 is the interrupt flag and bit 1 is overflow. Each period completion sets bit 0, and the irq port follows it. Writing 1 to a status bit clears it.
- R8: If a capture period exceeds the counter maximum, the counter holds at all-ones and the overflow bit is set. The closing edges then store all-ones as the period and as the width.
- R9: After capture is enabled, the first starting edge only arms the measurement. No result is stored and no interrupt is raised until a second starting edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, one cycle after the address |
| pin_in | input | 1 | Timer pin input (capture mode) |
| pin_out | output | 1 | Timer pin output value (generation mode) |
| pin_oe | output | 1 | Timer pin output enable |
| irq | output | 1 | Interrupt flag |

## Verification
The generation sweep covers every period from 0 to 6 against every width from 0 to 7. It counts high cycles over three whole periods, which separates the always-low case, the always-high case and the clipped-width case from normal pulses. The glitch test shrinks the width at each of the eight phases of an eight-cycle period. Only an update held to the boundary produces no pulse of intermediate length. The capture sweep uses every high and low duration from 1 to 6 cycles in both edge polarities, so swapped edges or an off-by-one in the start or stop count give distinct wrong numbers. One stretched pulse drives the counter into saturation, and a single lone edge shows that nothing is reported before the measurement is armed.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int REG_CTRL = 0;
  localparam int REG_PER  = 1;
  localparam int REG_WID  = 2;
  localparam int REG_CAPP = 3;
  localparam int REG_CAPW = 4;
  localparam int REG_STAT = 5;

  localparam int CTL_EN  = 0;
  localparam int CTL_CAP = 1;
  localparam int CTL_LOW = 2;

  localparam int ST_IRQ = 0;
  localparam int ST_OVF = 1;
endpackage

// File: rtl/timer_sync_edge.sv
module timer_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  if (STAGES > 1) begin : g_multi
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din};
    end
  end else begin : g_single
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  assign at_max = &cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)         cnt <= '0;
    else if (load_one)      cnt <= W'(1);
    else if (inc && !at_max) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/timer_pwm_ctl.sv
module timer_pwm_ctl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] per_sh,
  input  logic [W-1:0] wid_sh,
  input  logic [W-1:0] cnt,
  output logic         boundary,
  output logic [W-1:0] wid_act,
  output logic         pwm
);
  logic [W-1:0] per_act;
  logic [W:0]   nxt;

  assign nxt      = {1'b0, cnt} + (W+1)'(1);
  assign boundary = run && (nxt >= {1'b0, per_act});

  always_ff @(posedge clk) begin
    if (rst) begin
      per_act <= '0;
      wid_act <= '0;
      pwm     <= 1'b0;
    end else begin
      if (!run || boundary) begin
        per_act <= per_sh;
        wid_act <= wid_sh;
      end
      pwm <= run && (cnt < wid_act);
    end
  end
endmodule

// File: rtl/timer_capture_ctl.sv
module timer_capture_ctl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         meas_low,
  input  logic         rise,
  input  logic         fall,
  input  logic [W-1:0] cnt,
  input  logic         at_max,
  output logic         start,
  output logic         armed,
  output logic         done,
  output logic         ovf_set,
  output logic [W-1:0] cap_per,
  output logic [W-1:0] cap_wid
);
  logic         stop_w;
  logic [W-1:0] wid_tmp;

  assign start   = run & (meas_low ? fall : rise);
  assign stop_w  = run & armed & (meas_low ? rise : fall);
  assign done    = start & armed;
  assign ovf_set = run & armed & at_max & ~start;

  always_ff @(posedge clk) begin
    if (rst || !run) armed <= 1'b0;
    else if (start)  armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wid_tmp <= '0;
      cap_per <= '0;
      cap_wid <= '0;
    end else begin
      if (stop_w) wid_tmp <= cnt;
      if (done) begin
        cap_per <= cnt;
        cap_wid <= wid_tmp;
      end
    end
  end
endmodule

// File: rtl/pwm_capture_timer.sv
module pwm_capture_timer #(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq
);
  import timer_pkg::*;

  logic             ctl_en, ctl_cap, ctl_low;
  logic [CNT_W-1:0] per_sh, wid_sh;
  logic             flag_irq, flag_ovf;
  logic             run_gen, run_cap;
  logic             rise, fall;
  logic [CNT_W-1:0] cnt;
  logic             at_max;
  logic             ctr_clr, ctr_load, ctr_inc;
  logic             gen_boundary;
  logic [CNT_W-1:0] wid_act;
  logic             pwm;
  logic             cap_start, cap_armed, cap_done, cap_ovf_set;
  logic [CNT_W-1:0] cap_per, cap_wid;
  logic             wr_stat;
  logic             oe_q;
  logic [CNT_W-1:0] rdata_q;

  assign run_gen = ctl_en & ~ctl_cap;
  assign run_cap = ctl_en & ctl_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en  <= 1'b0;
      ctl_cap <= 1'b0;
      ctl_low <= 1'b0;
      per_sh  <= '0;
      wid_sh  <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADDR_W'(REG_CTRL)) begin
        ctl_en  <= bus_wdata[CTL_EN];
        ctl_cap <= bus_wdata[CTL_CAP];
        ctl_low <= bus_wdata[CTL_LOW];
      end
      if (bus_addr == ADDR_W'(REG_PER)) per_sh <= bus_wdata;
      if (bus_addr == ADDR_W'(REG_WID)) wid_sh <= bus_wdata;
    end
  end

  timer_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .rise(rise), .fall(fall)
  );

  assign ctr_clr  = run_gen ? gen_boundary : ~run_cap;
  assign ctr_load = run_cap & cap_start;
  assign ctr_inc  = run_gen | (run_cap & cap_armed);

  timer_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(ctr_clr), .load_one(ctr_load),
    .inc(ctr_inc), .cnt(cnt), .at_max(at_max)
  );

  timer_pwm_ctl #(.W(CNT_W)) u_pwm (
    .clk(clk), .rst(rst), .run(run_gen), .per_sh(per_sh), .wid_sh(wid_sh),
    .cnt(cnt), .boundary(gen_boundary), .wid_act(wid_act), .pwm(pwm)
  );

  timer_capture_ctl #(.W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .run(run_cap), .meas_low(ctl_low),
    .rise(rise), .fall(fall), .cnt(cnt), .at_max(at_max),
    .start(cap_start), .armed(cap_armed), .done(cap_done),
    .ovf_set(cap_ovf_set), .cap_per(cap_per), .cap_wid(cap_wid)
  );

  assign wr_stat = bus_we && (bus_addr == ADDR_W'(REG_STAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_irq <= 1'b0;
      flag_ovf <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      flag_irq <= cap_done | (flag_irq & ~(wr_stat & bus_wdata[ST_IRQ]));
      flag_ovf <= cap_ovf_set | (flag_ovf & ~(wr_stat & bus_wdata[ST_OVF]));
      oe_q     <= run_gen;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (bus_addr)
        ADDR_W'(REG_CTRL): rdata_q <= {{(CNT_W-3){1'b0}}, ctl_low, ctl_cap, ctl_en};
        ADDR_W'(REG_PER):  rdata_q <= per_sh;
        ADDR_W'(REG_WID):  rdata_q <= wid_sh;
        ADDR_W'(REG_CAPP): rdata_q <= cap_per;
        ADDR_W'(REG_CAPW): rdata_q <= cap_wid;
        ADDR_W'(REG_STAT): rdata_q <= {{(CNT_W-2){1'b0}}, flag_ovf, flag_irq};
        default:           rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = pwm;
  assign pin_oe    = oe_q;
  assign irq       = flag_irq;
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run_gen,
  input logic             gen_boundary,
  input logic [CNT_W-1:0] wid_act,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             ctl_cap,
  input logic             cap_done,
  input logic             irq,
  input logic             at_max,
  input logic             ctr_clr,
  input logic             ctr_load
);
  assert_zero_width_low_R2: assert property (@(posedge clk) disable iff (rst)
    (run_gen && wid_act == '0) |=> !pin_out);

  assert_width_held_R3: assert property (@(posedge clk) disable iff (rst)
    (run_gen && !gen_boundary) |=> $stable(wid_act));

  assert_no_drive_capture_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_cap |=> !pin_oe);

  assert_irq_after_latch_R7: assert property (@(posedge clk) disable iff (rst)
    cap_done |=> irq);

  assert_count_saturates_R8: assert property (@(posedge clk) disable iff (rst)
    (at_max && !ctr_clr && !ctr_load) |=> at_max);
endmodule

bind pwm_capture_timer timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run_gen(run_gen), .gen_boundary(gen_boundary),
  .wid_act(wid_act), .pin_out(pin_out), .pin_oe(pin_oe), .ctl_cap(ctl_cap),
  .cap_done(cap_done), .irq(irq), .at_max(at_max), .ctr_clr(ctr_clr),
  .ctr_load(ctr_load)
);

// File: tb/pwm_capture_timer_bench.sv
module pwm_capture_timer_bench;
  localparam int CW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          pin_in = 1'b0;
  logic          pin_out, pin_oe, irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pwm_capture_timer #(.CNT_W(CW), .ADDR_W(AW), .SYNC_STAGES(2)) u_pwm_capture_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = CW'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    d = int'(bus_rdata);
  endtask

  task automatic cap_case(int h, int l, bit low);
    int v;
    pin_in = 1'b0;
    wr(0, 0);
    wr(5, 3);
    repeat (4) @(negedge clk);
    wr(0, 3 | (int'(low) << 2));
    for (int k = 0; k < 4; k++) begin
      pin_in = 1'b1; repeat (h) @(negedge clk);
      pin_in = 1'b0; repeat (l) @(negedge clk);
    end
    pin_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(3, v);
    chk(low ? "R6 period fall-to-fall" : "R5 period rise-to-rise", v, h + l);
    rd(4, v);
    chk(low ? "R6 low width" : "R5 high width", v, low ? l : h);
    rd(5, v);
    chk("R7 status after periods", v, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_out", int'(pin_out), 0);
    chk("R1 pin_oe", int'(pin_oe), 0);
    chk("R1 irq", int'(irq), 0);
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk("R1 register reset", v, 0);
    end

    // R2 sweep: period 0..6 x width 0..7
    for (int p = 0; p <= 6; p++) begin
      for (int w = 0; w <= 7; w++) begin
        int eff, highs;
        wr(0, 0); wr(1, p); wr(2, w); wr(0, 1);
        repeat (16) @(negedge clk);
        eff = (p == 0) ? 1 : p;
        highs = 0;
        for (int i = 0; i < 3 * eff; i++) begin
          @(negedge clk);
          highs += int'(pin_out);
        end
        chk("R2 high cycles per three periods", highs, 3 * ((w < eff) ? w : eff));
      end
    end
    chk("R4 oe in generation", int'(pin_oe), 1);

    // R3 width change at every phase of an 8-cycle period
    for (int off = 0; off < 8; off++) begin
      int len, bad;
      bit counting, seen_new, prev;
      wr(0, 0); wr(1, 8); wr(2, 5); wr(0, 1);
      repeat (20 + off) @(negedge clk);
      wr(2, 2);
      len = 0; bad = 0; counting = 0; seen_new = 0; prev = pin_out;
      for (int i = 0; i < 48; i++) begin
        @(negedge clk);
        if (pin_out && !prev) begin counting = 1; len = 1; end
        else if (pin_out && counting) len++;
        else if (!pin_out && prev && counting) begin
          if (len == 2) seen_new = 1;
          else if (!(len == 5 && !seen_new)) bad++;
          counting = 0;
        end
        prev = pin_out;
      end
      if (!seen_new) bad++;
      chk("R3 pulses only of old or new width", bad, 0);
    end

    // R5/R6 capture sweep
    for (int h = 1; h <= 6; h++)
      for (int l = 1; l <= 6; l++) begin
        cap_case(h, l, 1'b0);
        cap_case(h, l, 1'b1);
      end
    chk("R4 oe in capture", int'(pin_oe), 0);

    // R7 clear by writing one
    chk("R7 irq port set", int'(irq), 1);
    wr(5, 1);
    chk("R7 irq port cleared", int'(irq), 0);
    rd(5, v);
    chk("R7 status cleared", v, 0);

    // R8 overflow
    pin_in = 1'b0;
    wr(0, 0); wr(5, 3);
    repeat (4) @(negedge clk);
    wr(0, 3);
    pin_in = 1'b1; repeat (300) @(negedge clk);
    pin_in = 1'b0; repeat (10) @(negedge clk);
    pin_in = 1'b1; repeat (6) @(negedge clk);
    rd(3, v); chk("R8 saturated period", v, 255);
    rd(4, v); chk("R8 saturated width", v, 255);
    rd(5, v); chk("R8 overflow and irq flags", v, 3);

    // R9 single starting edge stores nothing
    pin_in = 1'b0;
    wr(0, 0); wr(5, 3);
    repeat (4) @(negedge clk);
    wr(0, 7);
    pin_in = 1'b1; repeat (3) @(negedge clk);
    pin_in = 1'b0; repeat (8) @(negedge clk);
    rd(5, v); chk("R9 no irq after arming edge", v, 0);
    rd(3, v); chk("R9 captured period unchanged", v, 255);
    chk("R9 irq port low", int'(irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule